// File: doc/BRIEF.md
# Compare-Match Interval Timer (8-bit)

This block is an 8-bit up counter that raises a one-cycle interrupt pulse at a programmable interval. The counter advances on a count enable. That enable comes from one of several prescaled versions of the main clock, from the main clock itself, or from an externally supplied slow-clock enable. When the counter reaches the active compare value, the block pulses the interrupt and clears the counter. The interval is therefore the compare value times the period of the chosen source.

Software reaches the block over a small register bus with write and read strobes. Address 0 is the mode register and address 1 is the compare register. A separate run input starts and stops the timer. The compare value can optionally be double buffered: a value written while the timer runs is then held back until the next match, so the interval in progress is never disturbed.

Top module: `cmt8_timer`

## Requirements
- R1: Mode bits [2:0] select the count source. Codes 0 to 5 divide the main clock by 2048, 1024, 256, 64, 16 and 4. Code 6 counts every main-clock cycle. Code 7 counts on cycles where `slow_en` is high. Interval = compare value × source period, in main-clock cycles.
- R2: When the next count would equal the active compare value, `irq` is high for the cycle after that edge and the counter returns to zero. Between matches the counter only holds or steps by one.
- R3: A compare value of 0 gives an interval of 256 source periods.
- R4: After reset `irq` is 0 and the compare register reads 0. While `run` is low, the counter and prescaler are held at zero and no interrupt is raised. After `run` rises, the first interrupt comes compare × period + 1 clock edges later, counting the edge that samples `run`.
- R5: A compare write while stopped becomes active at once, whatever the state of the double-buffer bit.
- R6: With mode bit 3 (double buffer) clear, a compare write while running becomes active at once. A value below the next count gives no match until the counter wraps past 255 and counts up to it again.
- R7: With double buffer clear, a running write of a nonzero value equal to the current count raises `irq` in the cycle right after the write edge.
- R8: With double buffer set, a compare write while running is held back. The running interval ends at the old value, and the new value governs the intervals that follow.
- R9: A read strobe loads `bus_rdata` on the next edge. Address 1 returns the last compare byte written, even if that byte is not yet active. Address 0 returns the last mode byte written.
- R10: A clock-select change written while running has no effect until the timer has been stopped.
- R11: With code 7, one count is made per cycle in which `slow_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_en | input | 1 | External slow-clock count enable, used when the source code is 7 |
| run | input | 1 | High runs the timer, low stops and clears it |
| bus_addr | input | 1 | 0 = mode register, 1 = compare register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq | output | 1 | One-cycle interrupt pulse on a match |

## Verification
The checker watches several properties on every cycle. An interrupt always comes with a cleared counter, and a stopped timer stays silent at zero. The counter never jumps by more than one, the latched clock select is frozen while running, and a held-back compare write leaves the active value untouched. An equal-value write must fire on the next cycle, and the read-back register must track the last write. Only the bench scenarios can show the interval lengths for each source code, the wraparound delay after a write below the count, the 256-count meaning of zero, and the hand-over of a buffered value at the next match. These scenarios are checked against a behavioural model on every clock.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    // Count source codes, in the order the mode field decodes them
    typedef enum logic [2:0] {
        SRC_DIV2048 = 3'd0,
        SRC_DIV1024 = 3'd1,
        SRC_DIV256  = 3'd2,
        SRC_DIV64   = 3'd3,
        SRC_DIV16   = 3'd4,
        SRC_DIV4    = 3'd5,
        SRC_MAIN    = 3'd6,
        SRC_SLOW    = 3'd7
    } clk_src_e;

    localparam int SRC_CODES = 8;
    localparam int DIV_CODES = 6;

    // Mode field layout: bit 3 double-buffer enable, bits 2:0 source
    typedef struct packed {
        logic     dbuf;
        clk_src_e src;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic {
        REG_MODE = 1'b0,
        REG_CMP  = 1'b1
    } reg_sel_e;

    // Prescaler bits that must be all ones for a divided tick
    function automatic int tap_bits(input int code);
        case (code)
            0:       return 11;
            1:       return 10;
            2:       return 8;
            3:       return 6;
            4:       return 4;
            5:       return 2;
            default: return 1;
        endcase
    endfunction

    localparam int MAX_TAP = 11;

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int PRE_W = MAX_TAP
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     slow_en,
    input  clk_src_e src,
    output logic     tick
);

    logic [PRE_W-1:0]     pre_q;
    logic [SRC_CODES-1:0] tick_vec;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // One tap per divided source code
    for (genvar g = 0; g < DIV_CODES; g++) begin : g_tap
        localparam int TB = tap_bits(g);
        assign tick_vec[g] = &pre_q[TB-1:0];
    end

    assign tick_vec[SRC_MAIN] = 1'b1;
    assign tick_vec[SRC_SLOW] = slow_en;

    always_comb begin
        tick = !clr && tick_vec[src];
    end

endmodule

// File: rtl/cmt_cmpreg.sv
module cmt_cmpreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         running,
    input  logic         dbuf,
    input  logic         match,
    output logic         direct,
    output logic [W-1:0] cmp_act,
    output logic [W-1:0] cmp_eff,
    output logic [W-1:0] cmp_last
);

    logic pend_q;

    // A write goes straight to the active value unless it is buffered
    always_comb begin
        direct  = wr && (!running || !dbuf);
        cmp_eff = direct ? wdata : cmp_act;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_act  <= '0;
            cmp_last <= '0;
            pend_q   <= 1'b0;
        end else begin
            if (match && pend_q) begin
                cmp_act <= cmp_last;
                pend_q  <= 1'b0;
            end
            if (wr) begin
                cmp_last <= wdata;
                if (direct) begin
                    cmp_act <= wdata;
                    pend_q  <= 1'b0;
                end else begin
                    pend_q  <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         running,
    input  logic         tick,
    input  logic         direct_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cmp_eff,
    output logic [W-1:0] cnt,
    output logic         match,
    output logic         irq
);

    logic [W-1:0] cnt_inc;
    logic         hit_tick;
    logic         hit_write;

    always_comb begin
        cnt_inc   = cnt + 1'b1;
        // zero compare is reached by the wrap from all ones
        hit_tick  = tick && (cnt_inc == cmp_eff);
        hit_write = direct_wr && (wdata == cnt) && (cnt != '0);
        match     = running && (hit_tick || hit_write);
    end

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            cnt <= '0;
        end else if (match) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= match;
        end
    end

endmodule

// File: rtl/cmt8_timer.sv
module cmt8_timer
    import cmt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = MAX_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_en,
    input  logic              run,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic [DATA_W-1:0] mode_q;
    mode_t             mode_f;
    clk_src_e          src_act;
    logic              run_q;
    logic              wr_mode;
    logic              wr_cmp;
    logic              tick;
    logic              direct;
    logic              match;
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] cmp_act;
    logic [DATA_W-1:0] cmp_eff;
    logic [DATA_W-1:0] cmp_last;

    always_comb begin
        mode_f  = mode_t'(mode_q[MODE_W-1:0]);
        wr_mode = bus_wr && (reg_sel_e'(bus_addr) == REG_MODE);
        wr_cmp  = bus_wr && (reg_sel_e'(bus_addr) == REG_CMP);
    end

    // Mode byte, run state and the source latched while stopped
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            run_q   <= 1'b0;
            src_act <= SRC_DIV2048;
        end else begin
            if (wr_mode) begin
                mode_q <= bus_wdata;
            end
            run_q <= run;
            if (!run_q) begin
                src_act <= mode_f.src;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= (reg_sel_e'(bus_addr) == REG_CMP) ? cmp_last : mode_q;
        end
    end

    cmt_prescaler #(
        .PRE_W   (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clr     (!run_q),
        .slow_en (slow_en),
        .src     (src_act),
        .tick    (tick)
    );

    cmt_cmpreg #(
        .W        (DATA_W)
    ) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr_cmp),
        .wdata    (bus_wdata),
        .running  (run_q),
        .dbuf     (mode_f.dbuf),
        .match    (match),
        .direct   (direct),
        .cmp_act  (cmp_act),
        .cmp_eff  (cmp_eff),
        .cmp_last (cmp_last)
    );

    cmt_counter #(
        .W         (DATA_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .running   (run_q),
        .tick      (tick),
        .direct_wr (direct),
        .wdata     (bus_wdata),
        .cmp_eff   (cmp_eff),
        .cnt       (cnt),
        .match     (match),
        .irq       (irq)
    );

endmodule

// File: rtl/cmt8_timer_chk.sv
module cmt8_timer_chk
    import cmt_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         run_q,
    input logic         irq,
    input logic         match,
    input logic         wr_cmp,
    input logic         dbuf,
    input logic [W-1:0] wdata,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp_act,
    input logic [W-1:0] cmp_last,
    input clk_src_e     src_act
);

    // R2
    irq_clears_counter_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !match) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

    // R4
    stopped_silent_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> (!irq && (cnt == '0)));

    // R7
    equal_write_fires_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmp && run_q && !dbuf && (wdata == cnt) && (cnt != '0)) |=> irq);

    // R8
    buffered_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmp && run_q && dbuf && !match) |=> (cmp_act == $past(cmp_act)));

    // R9
    readback_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmp |=> (cmp_last == $past(wdata)));

    // R10
    source_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q)) |-> (src_act == $past(src_act)));

endmodule

bind cmt8_timer cmt8_timer_chk #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .run_q    (run_q),
    .irq      (irq),
    .match    (match),
    .wr_cmp   (wr_cmp),
    .dbuf     (mode_f.dbuf),
    .wdata    (bus_wdata),
    .cnt      (cnt),
    .cmp_act  (cmp_act),
    .cmp_last (cmp_last),
    .src_act  (src_act)
);

// File: tb/tb_cmt8_timer.sv
`timescale 1ns/1ps
module tb_cmt8_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slow_en = 1'b0;
    logic       run = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int sdiv = 0;

    cmt8_timer dut (
        .clk       (clk),
        .rst       (rst),
        .slow_en   (slow_en),
        .run       (run),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    // slow enable: one cycle high in every seven
    always @(negedge clk) begin
        sdiv = (sdiv + 1) % 7;
        slow_en <= (sdiv == 0);
    end

    // ---------------- behavioural reference model ----------------
    int m_run, m_pre, m_cnt, m_cmp, m_last, m_pend, m_mode, m_sel, m_irq, m_rdata;

    always @(posedge clk) begin : model
        int per, tk, db, dir, imm, eff, tgt, mt, nc;
        if (rst) begin
            m_run = 0; m_pre = 0; m_cnt = 0; m_cmp = 0; m_last = 0;
            m_pend = 0; m_mode = 0; m_sel = 0; m_irq = 0; m_rdata = 0;
        end else begin
            if (bus_rd) m_rdata = bus_addr ? m_last : m_mode;
            case (m_sel)
                0: per = 2048;
                1: per = 1024;
                2: per = 256;
                3: per = 64;
                4: per = 16;
                5: per = 4;
                default: per = 1;
            endcase
            if (m_run == 0) tk = 0;
            else if (m_sel == 7) tk = slow_en;
            else tk = ((m_pre % per) == per - 1) ? 1 : 0;
            db  = (m_mode >> 3) & 1;
            dir = (bus_wr && bus_addr && (m_run == 0 || db == 0)) ? 1 : 0;
            imm = (dir && m_run && int'(bus_wdata) == m_cnt && m_cnt != 0) ? 1 : 0;
            eff = dir ? int'(bus_wdata) : m_cmp;
            tgt = (eff == 0) ? 256 : eff;
            mt  = (m_run && (imm || (tk && m_cnt + 1 == tgt))) ? 1 : 0;
            if (m_run == 0 || mt) nc = 0;
            else if (tk) nc = (m_cnt + 1) % 256;
            else nc = m_cnt;
            if (mt && m_pend) begin
                m_cmp = m_last;
                m_pend = 0;
            end
            if (bus_wr && bus_addr) begin
                m_last = bus_wdata;
                if (dir) begin
                    m_cmp = bus_wdata;
                    m_pend = 0;
                end else begin
                    m_pend = 1;
                end
            end
            if (m_run == 0) m_sel = m_mode & 7;
            if (bus_wr && !bus_addr) m_mode = bus_wdata;
            m_pre = m_run ? (m_pre + 1) % 2048 : 0;
            m_cnt = nc;
            m_irq = mt;
            m_run = run ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R2 model irq", int'(irq), m_irq);
            chk("R9 model rdata", int'(bus_rdata), m_rdata);
        end
    end

    // ---------------- stimulus helpers (called at a negedge) ----------------
    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output int d);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic count_to_irq(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!irq && n < 20000);
        if (!irq) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: irq missing after actual %0d expected fewer", n);
        end
    endtask

    task automatic wait_edges(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stop_timer();
        run = 1'b0;
        wait_edges(3);
    endtask

    initial begin
        int n, rd, seen;
        int divs[6];
        int cmps[6];
        divs = '{2048, 1024, 256, 64, 16, 4};
        cmps = '{2, 1, 3, 2, 4, 3};

        wait_edges(3);
        rst = 1'b0;
        chk("R4 reset irq", int'(irq), 0);
        bus_read(1'b1, rd);
        chk("R4 reset compare read", rd, 0);

        // main clock, compare 5
        bus_write(1'b0, 8'h06);
        bus_write(1'b1, 8'd5);
        run = 1'b1;
        count_to_irq(n); chk("R4 first irq after start", n, 6);
        wait_edges(0);
        chk("R2 one-cycle pulse", int'(irq), 0);
        count_to_irq(n); chk("R2 interval 5", n, 4);
        count_to_irq(n); chk("R2 interval 5 steady", n, 5);

        // R7: equal value written while running fires at once
        wait_edges(2);
        bus_write(1'b1, 8'd2);
        chk("R7 equal write irq", int'(irq), 1);
        count_to_irq(n); chk("R7 interval after equal write", n, 2);

        // R6: write below the count waits for wraparound
        bus_write(1'b1, 8'd200);
        count_to_irq(n);
        count_to_irq(n); chk("R6 interval 200", n, 200);
        wait_edges(50);
        bus_write(1'b1, 8'd20);
        count_to_irq(n); chk("R6 wraparound delay", n, 225);
        count_to_irq(n); chk("R6 interval 20 after wrap", n, 20);

        // R3: zero means 256
        bus_write(1'b1, 8'd0);
        count_to_irq(n); chk("R3 remaining after zero write", n, 255);
        count_to_irq(n); chk("R3 interval 256", n, 256);

        // R8: buffered writes
        bus_write(1'b0, 8'h0E);
        bus_write(1'b1, 8'd10);
        count_to_irq(n); chk("R8 old interval completes", n, 254);
        count_to_irq(n); chk("R8 new value after match", n, 10);
        wait_edges(3);
        bus_write(1'b1, 8'd40);
        bus_read(1'b1, rd); chk("R9 read pending compare", rd, 40);
        count_to_irq(n); chk("R8 held write keeps old match", n, 5);
        count_to_irq(n); chk("R8 interval 40", n, 40);

        // R10: source change ignored while running
        bus_write(1'b0, 8'h0C);
        bus_read(1'b0, rd); chk("R9 read mode", rd, 12);
        count_to_irq(n);
        count_to_irq(n); chk("R10 source unchanged while running", n, 40);

        // R4: stopped timer is silent
        run = 1'b0;
        seen = 0;
        for (int i = 0; i < 50; i++) begin
            @(posedge clk); @(negedge clk);
            if (irq) seen = 1;
        end
        chk("R4 no irq while stopped", seen, 0);

        // R5: write while stopped with buffering on is active at once
        bus_write(1'b1, 8'd8);
        run = 1'b1;
        count_to_irq(n); chk("R5 stopped write active, R10 new source", n, 129);
        count_to_irq(n); chk("R1 divide-16 interval", n, 128);

        // R1: every divided source
        for (int s = 0; s < 6; s++) begin
            stop_timer();
            bus_write(1'b0, 8'(s));
            bus_write(1'b1, 8'(cmps[s]));
            run = 1'b1;
            count_to_irq(n); chk($sformatf("R1 first irq code %0d", s), n, cmps[s] * divs[s] + 1);
            count_to_irq(n); chk($sformatf("R1 interval code %0d", s), n, cmps[s] * divs[s]);
        end

        // R11: slow enable source
        stop_timer();
        bus_write(1'b0, 8'h07);
        bus_write(1'b1, 8'd3);
        run = 1'b1;
        count_to_irq(n);
        count_to_irq(n); chk("R11 slow source interval", n, 21);

        stop_timer();
        finish_run();
    end

endmodule